// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block drives an 8-bit, two-line character LCD module through one shared 8-bit bus and two write strobes: one strobe for the instruction register and one for the data register. It does not read the panel's busy flag. After every write it waits a fixed settling time, and it takes each of these times from a cycle counter. The counter's reload values are computed at elaboration from a clock-frequency parameter and rounded up to whole cycles.

After reset the sequencer runs the panel's power-up wake-up by itself. This is three function-set writes with waits that get shorter each time, then display-on, then clear. It then prints a fixed boot banner at cursor position 0. Only after that does it raise `req_ready`.

A host then issues requests over a valid/ready handshake. A request is one of three things. It can be a character string, which comes in one byte per handshake, ends with a last flag and starts at a given cursor position. It can also be a shift of the whole display to the left or to the right. A request that arrives while a settling wait is pending is held off by `req_ready` and is never lost.

Top module: `lcd_cmd_seq`

## Requirements
- R1: While reset is asserted, both strobes are low, `req_ready` is low and `busy` is high. `req_ready` stays low until the whole power-up sequence and the banner have been written.
- R2: After reset the instruction port receives 0x38, 0x38, 0x38, 0x0C, 0x01 in that order. The strobe-to-strobe gaps after each of these writes are at least 5000 us, 200 us, 50 us, 50 us and 10000 us respectively.
- R3: After the power-up sequence, the instruction 0x80 is written, and after at least 100 us the banner characters (default "BOOT OK") follow on the data port. Each character is followed by at least 200 us before the next write of any kind.
- R4: A string request writes instruction 0x80 OR the 7-bit position, waits at least 100 us, then writes each character to the data port with at least 200 us after each. During a string, the op field of the continuation beats is ignored. The string ends at the beat with `req_last` = 1.
- R5: A shift-left request writes instruction 0x18, followed by at least 50 us before the next write.
- R6: A shift-right request writes instruction 0x1C, followed by at least 50 us before the next write.
- R7: `req_op` encoding: 2'b00 is a string, 2'b01 is shift left, 2'b10 is shift right. 2'b11 is accepted and produces no write at all.
- R8: Each write drives `lcd_data` together with a strobe one cycle wide on exactly one of `lcd_instr_we` or `lcd_data_we`, never both.
- R9: `req_ready` is low while a settling wait is pending. A request held with `req_valid` high during that time is taken later and carried out in order. `busy` is high except when idle between requests.
- R10: Each wait of T us lasts ceil(CLK_HZ * T / 1e6) cycles, measured strobe to strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host beat valid |
| req_ready | output | 1 | Sequencer can take a beat this cycle |
| req_op | input | 2 | Operation: 00 string, 01 shift left, 10 shift right, 11 no-op |
| req_pos | input | 7 | Cursor position for the first beat of a string |
| req_byte | input | 8 | Character for a string beat |
| req_last | input | 1 | Marks the final character of a string |
| lcd_data | output | 8 | Panel data bus |
| lcd_instr_we | output | 1 | One-cycle instruction-register write strobe |
| lcd_data_we | output | 1 | One-cycle data-register write strobe |
| busy | output | 1 | Power-up, a write or a string in progress |

## Verification
The embedded assertions check every cycle that no two strobes coincide. They check that every strobe keeps the minimum distance owed to the write before it. They also check that a no-op beat never yields a strobe, and that ready stays low until power-up is complete. The bench's scenarios are needed to show:
- the exact byte order of the wake-up sequence, the banner and the host strings;
- the correct command codes for the two shifts;
- the rounding of the wait lengths at a clock rate that does not divide evenly;
- that a request held off during a wait is carried out afterwards rather than dropped.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    OP_STRING = 2'b00,
    OP_SHL    = 2'b01,
    OP_SHR    = 2'b10,
    OP_NOP    = 2'b11
  } lcd_op_e;

  localparam logic [7:0] CMD_FUNC_SET = 8'h38;
  localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
  localparam logic [7:0] CMD_CLEAR    = 8'h01;
  localparam logic [7:0] CMD_SET_ADDR = 8'h80;
  localparam logic [7:0] CMD_SHL      = 8'h18;
  localparam logic [7:0] CMD_SHR      = 8'h1C;

  localparam int INIT_STEPS = 5;

  // Microseconds to clock cycles, rounded up.
  function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned us);
    return (clk_hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction

  function automatic logic [7:0] init_code(input int step);
    case (step)
      3:       return CMD_DISP_ON;
      4:       return CMD_CLEAR;
      default: return CMD_FUNC_SET;
    endcase
  endfunction

  function automatic longint unsigned init_wait_us(input int step);
    case (step)
      0:       return 64'd5000;
      1:       return 64'd200;
      4:       return 64'd10000;
      default: return 64'd50;
    endcase
  endfunction

endpackage

// File: rtl/lcd_gap_timer.sv
module lcd_gap_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_cycles,
  output logic          idle
);
  logic [TW-1:0] cnt;

  // Loading N-1 lets the next write issue exactly N cycles after this one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_cycles - TW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - TW'(1);
    end
  end

  assign idle = (cnt == '0);

endmodule

// File: rtl/lcd_bus_drv.sv
module lcd_bus_drv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       to_data,
  input  logic [7:0] wr_byte,
  output logic [7:0] lcd_data,
  output logic       lcd_instr_we,
  output logic       lcd_data_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcd_data     <= '0;
      lcd_instr_we <= 1'b0;
      lcd_data_we  <= 1'b0;
    end else begin
      lcd_instr_we <= go && !to_data;
      lcd_data_we  <= go && to_data;
      if (go) lcd_data <= wr_byte;
    end
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lcd_instr_we, lcd_data_we}));

endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd50_000_000,
  parameter int              BANNER_LEN = 7,
  parameter logic [8*BANNER_LEN-1:0] BANNER = "BOOT OK",
  parameter int              TW         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          timer_idle,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [6:0]    req_pos,
  input  logic [7:0]    req_byte,
  input  logic          req_last,
  output logic          req_ready,
  output logic          go,
  output logic          to_data,
  output logic [7:0]    wr_byte,
  output logic [TW-1:0] wait_cycles,
  output logic          busy
);
  localparam int IDX_MAX = (BANNER_LEN - 1 > INIT_STEPS - 1) ? BANNER_LEN - 1 : INIT_STEPS - 1;
  localparam int IW      = $clog2(IDX_MAX + 1) + 1;

  localparam logic [TW-1:0] W50  = TW'(us_to_cycles(CLK_HZ, 64'd50));
  localparam logic [TW-1:0] W100 = TW'(us_to_cycles(CLK_HZ, 64'd100));
  localparam logic [TW-1:0] W200 = TW'(us_to_cycles(CLK_HZ, 64'd200));

  typedef enum logic [2:0] {
    ST_INIT, ST_BPOS, ST_BCHR, ST_IDLE, ST_SPOS, ST_SCHR, ST_SNEXT
  } st_e;

  st_e           state;
  logic [IW-1:0] idx;
  logic [6:0]    pos_q;
  logic [7:0]    chr_q;
  logic          last_q;
  logic          init_done;
  logic          accept;
  lcd_op_e       op;

  function automatic logic [TW-1:0] init_wait(input logic [IW-1:0] step);
    return TW'(us_to_cycles(CLK_HZ, init_wait_us(int'(step))));
  endfunction

  function automatic logic [7:0] banner_char(input logic [IW-1:0] i);
    int k;
    k = (int'(i) < BANNER_LEN) ? int'(i) : 0;
    return BANNER[8*(BANNER_LEN-1-k) +: 8];
  endfunction

  assign op        = lcd_op_e'(req_op);
  assign req_ready = timer_idle && (state == ST_IDLE || state == ST_SNEXT);
  assign accept    = req_valid && req_ready;
  assign busy      = !(timer_idle && state == ST_IDLE);

  always_comb begin
    go          = 1'b0;
    to_data     = 1'b0;
    wr_byte     = CMD_SHL;
    wait_cycles = W50;
    unique case (state)
      ST_INIT: begin
        go          = timer_idle;
        wr_byte     = init_code(int'(idx));
        wait_cycles = init_wait(idx);
      end
      ST_BPOS: begin
        go          = timer_idle;
        wr_byte     = CMD_SET_ADDR;
        wait_cycles = W100;
      end
      ST_BCHR: begin
        go          = timer_idle;
        to_data     = 1'b1;
        wr_byte     = banner_char(idx);
        wait_cycles = W200;
      end
      ST_IDLE: begin
        go      = accept && (op == OP_SHL || op == OP_SHR);
        wr_byte = (op == OP_SHR) ? CMD_SHR : CMD_SHL;
      end
      ST_SPOS: begin
        go          = timer_idle;
        wr_byte     = CMD_SET_ADDR | {1'b0, pos_q};
        wait_cycles = W100;
      end
      ST_SCHR: begin
        go          = timer_idle;
        to_data     = 1'b1;
        wr_byte     = chr_q;
        wait_cycles = W200;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_INIT;
      idx       <= '0;
      pos_q     <= '0;
      chr_q     <= '0;
      last_q    <= 1'b0;
      init_done <= 1'b0;
    end else begin
      unique case (state)
        ST_INIT: if (go) begin
          if (idx == IW'(INIT_STEPS - 1)) begin
            idx   <= '0;
            state <= ST_BPOS;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_BPOS: if (go) state <= ST_BCHR;
        ST_BCHR: if (go) begin
          if (idx == IW'(BANNER_LEN - 1)) begin
            idx       <= '0;
            init_done <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_IDLE: if (accept && op == OP_STRING) begin
          pos_q  <= req_pos;
          chr_q  <= req_byte;
          last_q <= req_last;
          state  <= ST_SPOS;
        end
        ST_SPOS: if (go) state <= ST_SCHR;
        ST_SCHR: if (go) state <= last_q ? ST_IDLE : ST_SNEXT;
        ST_SNEXT: if (accept) begin
          chr_q  <= req_byte;
          last_q <= req_last;
          state  <= ST_SCHR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_init_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd50_000_000,
  parameter int              BANNER_LEN = 7,
  parameter logic [8*BANNER_LEN-1:0] BANNER = "BOOT OK"
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [6:0] req_pos,
  input  logic [7:0] req_byte,
  input  logic       req_last,
  output logic [7:0] lcd_data,
  output logic       lcd_instr_we,
  output logic       lcd_data_we,
  output logic       busy
);
  localparam longint unsigned MAX_CYC = us_to_cycles(CLK_HZ, 64'd10000);
  localparam int TW = $clog2(MAX_CYC + 1) + 1;

  logic          timer_idle;
  logic          go;
  logic          to_data;
  logic [7:0]    wr_byte;
  logic [TW-1:0] wait_cycles;

  lcd_seq_fsm #(
    .CLK_HZ(CLK_HZ), .BANNER_LEN(BANNER_LEN), .BANNER(BANNER), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .timer_idle(timer_idle),
    .req_valid(req_valid), .req_op(req_op), .req_pos(req_pos),
    .req_byte(req_byte), .req_last(req_last), .req_ready(req_ready),
    .go(go), .to_data(to_data), .wr_byte(wr_byte),
    .wait_cycles(wait_cycles), .busy(busy)
  );

  lcd_gap_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(go), .load_cycles(wait_cycles),
    .idle(timer_idle)
  );

  lcd_bus_drv u_bus (
    .clk(clk), .rst_n(rst_n), .go(go), .to_data(to_data), .wr_byte(wr_byte),
    .lcd_data(lcd_data), .lcd_instr_we(lcd_instr_we), .lcd_data_we(lcd_data_we)
  );

  // Gap observation for assertions: cycles since the last strobe and the
  // settling time owed by that strobe.
  logic          strobe;
  logic [TW:0]   since_last;
  logic [TW-1:0] need_q;
  logic [TW-1:0] prev_need;
  logic          seen_strobe;

  assign strobe = lcd_instr_we || lcd_data_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_last  <= '0;
      need_q      <= '0;
      prev_need   <= '0;
      seen_strobe <= 1'b0;
    end else begin
      if (go) need_q <= wait_cycles;
      if (strobe) begin
        since_last  <= (TW+1)'(1);
        prev_need   <= need_q;
        seen_strobe <= 1'b1;
      end else if (since_last != '1) begin
        since_last <= since_last + (TW+1)'(1);
      end
    end
  end

  p_gap_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && seen_strobe) |-> (since_last >= {1'b0, prev_need}));

  p_nop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |=> !strobe);

endmodule

// File: tb/lcd_cmd_seq_tb.sv
module lcd_cmd_seq_tb;
  localparam longint unsigned HZ = 64'd1_234_567;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'b00;
  logic [6:0] req_pos = '0;
  logic [7:0] req_byte = '0;
  logic       req_last = 1'b0;
  logic [7:0] lcd_data;
  logic       lcd_instr_we;
  logic       lcd_data_we;
  logic       busy;

  always #2.5 clk = ~clk;

  lcd_cmd_seq #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pos(req_pos), .req_byte(req_byte),
    .req_last(req_last), .lcd_data(lcd_data), .lcd_instr_we(lcd_instr_we),
    .lcd_data_we(lcd_data_we), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int n_log = 0;
  int lg_cyc [0:63];
  bit lg_dat [0:63];
  logic [7:0] lg_b [0:63];
  int bad_strobe = 0;
  bit prev_str = 1'b0;

  // Ceiling of hz*us/1e6 via quotient and remainder.
  function automatic int cyc_of(input int us);
    longint unsigned p;
    p = HZ * longint'(us);
    return int'(p / 1_000_000) + ((p % 1_000_000) != 0 ? 1 : 0);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_instr_we && lcd_data_we) bad_strobe++;
      if ((lcd_instr_we || lcd_data_we) && prev_str) bad_strobe++;
      if ((lcd_instr_we || lcd_data_we) && n_log < 64) begin
        lg_cyc[n_log] = cyc;
        lg_dat[n_log] = lcd_data_we;
        lg_b[n_log]   = lcd_data;
        n_log++;
      end
      prev_str = lcd_instr_we || lcd_data_we;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_log(input int n);
    while (n_log < n) @(negedge clk);
  endtask

  task automatic check_entry(input int i, input bit dat, input logic [7:0] b,
                             input int mingap, input string tag);
    chk(i < n_log, {tag, " entry present"}, n_log, i + 1);
    if (i < n_log) begin
      chk(lg_dat[i] == dat, {tag, " port"}, int'(lg_dat[i]), int'(dat));
      chk(lg_b[i] == b, {tag, " byte"}, int'(lg_b[i]), int'(b));
      if (i > 0)
        chk(lg_cyc[i] - lg_cyc[i-1] >= mingap, {tag, " gap"},
            lg_cyc[i] - lg_cyc[i-1], mingap);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [6:0] pos,
                      input logic [7:0] b, input bit last);
    @(negedge clk);
    req_op = op; req_pos = pos; req_byte = b; req_last = last;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!lcd_instr_we && !lcd_data_we, "R1 strobes in reset", int'(lcd_instr_we), 0);
    chk(!req_ready, "R1 ready in reset", int'(req_ready), 0);
    chk(busy, "R1 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!req_ready, "R1 ready during init", int'(req_ready), 0);
  endtask

  task automatic t_init;
    logic [7:0] ban [0:6];
    ban = '{8'h42, 8'h4F, 8'h4F, 8'h54, 8'h20, 8'h4F, 8'h4B};
    wait_log(13);
    check_entry(0, 1'b0, 8'h38, 0, "R2 fset1");
    check_entry(1, 1'b0, 8'h38, cyc_of(5000), "R2 fset2");
    check_entry(2, 1'b0, 8'h38, cyc_of(200), "R2 fset3");
    check_entry(3, 1'b0, 8'h0C, cyc_of(50), "R2 disp on");
    check_entry(4, 1'b0, 8'h01, cyc_of(50), "R2 clear");
    check_entry(5, 1'b0, 8'h80, cyc_of(10000), "R2 banner pos after clear");
    chk(lg_cyc[1] - lg_cyc[0] == 6173, "R10 rounded 5 ms", lg_cyc[1] - lg_cyc[0], 6173);
    for (int i = 0; i < 7; i++)
      check_entry(6 + i, 1'b1, ban[i], (i == 0) ? cyc_of(100) : cyc_of(200), "R3 banner");
    chk(!req_ready, "R9 ready low after banner char", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    chk(cyc - lg_cyc[12] >= cyc_of(200) - 1, "R3 ready after last wait",
        cyc - lg_cyc[12], cyc_of(200) - 1);
    chk(!busy, "R9 busy low when idle", int'(busy), 0);
  endtask

  task automatic t_string;
    int b;
    b = n_log;
    send(2'b00, 7'h45, "x", 1'b0);
    chk(!req_ready, "R9 ready low after string start", int'(req_ready), 0);
    send(2'b01, 7'h00, "y", 1'b0);   // op ignored mid-string
    chk(busy, "R9 busy during string", int'(busy), 1);
    send(2'b00, 7'h00, "z", 1'b1);
    wait_log(b + 4);
    check_entry(b,     1'b0, 8'hC5, cyc_of(200), "R4 position");
    check_entry(b + 1, 1'b1, "x", cyc_of(100), "R4 char x");
    check_entry(b + 2, 1'b1, "y", cyc_of(200), "R4 char y op ignored");
    check_entry(b + 3, 1'b1, "z", cyc_of(200), "R4 char z");
  endtask

  task automatic t_shifts_holdoff;
    int b;
    b = n_log;
    send(2'b01, 7'h00, 8'h00, 1'b0);
    chk(!req_ready, "R9 ready low after shift", int'(req_ready), 0);
    send(2'b10, 7'h00, 8'h00, 1'b0);   // held off during the 50 us wait
    wait_log(b + 2);
    check_entry(b,     1'b0, 8'h18, cyc_of(200), "R5 shift left");
    check_entry(b + 1, 1'b0, 8'h1C, cyc_of(50), "R6 shift right held");
    chk(lg_cyc[b+1] - lg_cyc[b] == 62, "R10 rounded 50 us", lg_cyc[b+1] - lg_cyc[b], 62);
  endtask

  task automatic t_nop;
    int b;
    b = n_log;
    send(2'b11, 7'h12, 8'h55, 1'b1);
    repeat (300) @(negedge clk);
    chk(n_log == b, "R7 no-op writes nothing", n_log, b);
    chk(req_ready, "R7 ready after no-op", int'(req_ready), 1);
    send(2'b00, 7'h00, "q", 1'b1);
    wait_log(b + 2);
    check_entry(b,     1'b0, 8'h80, cyc_of(50), "R7 string after no-op");
    check_entry(b + 1, 1'b1, "q", cyc_of(100), "R4 single char");
  endtask

  initial begin
    t_reset();
    t_init();
    t_string();
    t_shifts_holdoff();
    t_nop();
    repeat (10) @(negedge clk);
    chk(bad_strobe == 0, "R8 single one-cycle strobe", bad_strobe, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule